// File: doc/BRIEF.md
# Dual-Channel External Interrupt Request Controller

This block turns two asynchronous external pins into interrupt requests for a small microcontroller core. Each pin passes through a two-flop synchronizer and a width qualifier. A level change only counts once the new level has been seen unbroken for a set number of system clocks. Each channel has a 4-bit control register. Bit 3 enables the pin. Bits [2:1] pick which qualified transitions are valid: falling, rising, or both. A valid transition sets that channel's request flag.

A flag turns into a core interrupt only when its bit in the interrupt-enable register is set and the global enable input is high. If it does not, software polls the flag with a skip-test strobe. The strobe returns the flag's state on the following cycle and clears the flag. An acknowledge strobe carries a channel index and clears only that channel's flag. When both channels request at once, channel 0 is presented first.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Each channel has a 4-bit control register, loaded from `cfg_wdata_i` when its `cfg_we_i` bit is high. Channel n appears on `cfg_o[4n+3:4n]` exactly as written, from the cycle after the write.
- R2: The synchronized level must stay at its new value for 4 consecutive clocks before it counts. Any return to the old level restarts the count. A pin change made before clock edge k sets the flag at edge k+5. A pulse 3 clocks wide sets nothing.
- R3: Control bits [2:1] select the valid transition: 00 = falling only, 01 = rising only, 10 or 11 = both. A qualified transition of the other polarity leaves the flag at 0.
- R4: While control bit 3 is 0, pin activity never sets the flag. Setting bit 3 while the pin is held high does not create a transition.
- R5: An `ack_i` strobe clears only the flag whose index is on `ack_idx_i`.
- R6: A `skip_i` strobe drives `skip_hit_o` on the next cycle to the state that flag `skip_idx_i` had, and clears that flag. Without a strobe, `skip_hit_o` is 0.
- R7: `irq_o` is registered. It is 1 one cycle after some flag n is set while bit n of the interrupt-enable register (written through `ien_we_i`/`ien_wdata_i`) and `gie_i` are both 1. Otherwise it is 0.
- R8: When both channels qualify, `irq_idx_o` is 0. Once channel 0 is cleared, it shows 1.
- R9: If a set and a clear (acknowledge or skip-test) reach the same flag in the same cycle, the flag ends at 1.
- R10: After synchronous reset, all flags, control registers, enables, `irq_o`, `irq_idx_o` and `skip_hit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Asynchronous external interrupt pins |
| cfg_we_i | input | NCH | Per-channel control register write strobe |
| cfg_wdata_i | input | 4 | Control register write data |
| cfg_o | output | 4*NCH | Control registers, channel n in bits [4n+3:4n] |
| ien_we_i | input | 1 | Interrupt-enable register write strobe |
| ien_wdata_i | input | NCH | Interrupt-enable write data, bit n for channel n |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Interrupt acceptance strobe |
| ack_idx_i | input | IW | Channel accepted |
| skip_i | input | 1 | Skip-test strobe |
| skip_idx_i | input | IW | Channel tested |
| flag_o | output | NCH | Request flags |
| skip_hit_o | output | 1 | Skip-test result, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | IW | Channel of the presented request |

## Verification
The checker looks at every cycle. It confirms that a disabled channel never produces a set pulse, that an acknowledge or skip-test clears the indexed flag unless a set collides with it, and that a set always leaves the flag at 1. It also confirms that `skip_hit_o` reflects the tested flag, that `irq_o` never rises without the global and channel enables, and that channel 0 wins the index. Only the bench scenarios can show the width qualifier's exact latency, the rejection of a 3-clock pulse, each edge-select encoding, and the absence of a spurious transition at enable time. The same holds for register readback and channel isolation of the acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CFG_W      = 4;
  localparam int CFG_EN_BIT = 3;
  localparam int CFG_SEL_LO = 1;

  typedef enum logic [1:0] {
    SEL_FALL  = 2'b00,
    SEL_RISE  = 2'b01,
    SEL_BOTH  = 2'b10,
    SEL_BOTH2 = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
    logic hit;
    unique case (sel)
      SEL_FALL: hit = fall;
      SEL_RISE: hit = rise;
      default:  hit = rise | fall;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  assign take = en_i && (din_i != lvl_q) && (cnt_q == CW'(STABLE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      lvl_q <= din_i;
      cnt_q <= '0;
    end else if (din_i == lvl_q) begin
      cnt_q <= '0;
    end else if (take) begin
      lvl_q <= din_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_o = take &  din_i;
  assign fall_o = take & ~din_i;
endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
  import ext_irq_pkg::*;
#(
  parameter int STABLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             flag_o,
  output logic             set_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             flag_q;
  logic             pin_s;
  logic             rise;
  logic             fall;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
  );

  ext_irq_filter #(.STABLE(STABLE)) u_filt (
    .clk(clk), .rst(rst), .en_i(cfg_q[CFG_EN_BIT]), .din_i(pin_s),
    .rise_o(rise), .fall_o(fall)
  );

  assign set_o = edge_hit(edge_sel_e'(cfg_q[CFG_SEL_LO +: 2]), rise, fall);

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_o) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int STABLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NCH-1:0]                        pin_i,
  input  logic [NCH-1:0]                        cfg_we_i,
  input  logic [CFG_W-1:0]                      cfg_wdata_i,
  output logic [NCH*CFG_W-1:0]                  cfg_o,
  input  logic                                  ien_we_i,
  input  logic [NCH-1:0]                        ien_wdata_i,
  input  logic                                  gie_i,
  input  logic                                  ack_i,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ack_idx_i,
  input  logic                                  skip_i,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] skip_idx_i,
  output logic [NCH-1:0]                        flag_o,
  output logic                                  skip_hit_o,
  output logic                                  irq_o,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] irq_idx_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] ien_q;
  logic [NCH-1:0] set_vec;
  logic [NCH-1:0] flag_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] pend;
  logic [IW-1:0]  pick;
  logic           skip_hit_q;
  logic           irq_q;
  logic [IW-1:0]  irq_idx_q;

  always_ff @(posedge clk) begin
    if (rst)           ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_wdata_i;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign clr_vec[n] = (ack_i  && (ack_idx_i  == IW'(n))) ||
                        (skip_i && (skip_idx_i == IW'(n)));

    ext_irq_channel #(.STABLE(STABLE), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .pin_i      (pin_i[n]),
      .cfg_we_i   (cfg_we_i[n]),
      .cfg_wdata_i(cfg_wdata_i),
      .clr_i      (clr_vec[n]),
      .cfg_o      (cfg_o[n*CFG_W +: CFG_W]),
      .flag_o     (flag_vec[n]),
      .set_o      (set_vec[n])
    );
  end

  assign pend = flag_vec & ien_q & {NCH{gie_i}};

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      irq_idx_q  <= '0;
      skip_hit_q <= 1'b0;
    end else begin
      irq_q      <= |pend;
      irq_idx_q  <= pick;
      skip_hit_q <= skip_i && flag_vec[skip_idx_i];
    end
  end

  assign flag_o     = flag_vec;
  assign irq_o      = irq_q;
  assign irq_idx_o  = irq_idx_q;
  assign skip_hit_o = skip_hit_q;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int IW  = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 gie_i,
  input logic                 ack_i,
  input logic [IW-1:0]        ack_idx_i,
  input logic                 skip_i,
  input logic [IW-1:0]        skip_idx_i,
  input logic [NCH-1:0]       flag_o,
  input logic                 skip_hit_o,
  input logic                 irq_o,
  input logic [IW-1:0]        irq_idx_o,
  input logic [NCH*CFG_W-1:0] cfg_o,
  input logic [NCH-1:0]       ien_q,
  input logic [NCH-1:0]       set_vec
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
      !cfg_o[c*CFG_W + CFG_EN_BIT] |-> !set_vec[c]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_vec[c] |=> flag_o[c]);
  end

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_i && !set_vec[ack_idx_i] |=> !flag_o[$past(ack_idx_i)]);

  a_r6_skip_clears: assert property (@(posedge clk) disable iff (rst)
    skip_i && !set_vec[skip_idx_i] |=> !flag_o[$past(skip_idx_i)]);

  a_r6_skip_report: assert property (@(posedge clk) disable iff (rst)
    skip_i |=> skip_hit_o == $past(flag_o[skip_idx_i]));

  a_r6_skip_idle: assert property (@(posedge clk) disable iff (rst)
    !skip_i |=> !skip_hit_o);

  a_r7_irq_gie: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(gie_i));

  a_r7_irq_enabled: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flag_o & ien_q)));

  a_r8_ch0_first: assert property (@(posedge clk) disable iff (rst)
    irq_o && $past(flag_o[0] && ien_q[0] && gie_i) |-> irq_idx_o == '0);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NCH(NCH), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gie_i     (gie_i),
  .ack_i     (ack_i),
  .ack_idx_i (ack_idx_i),
  .skip_i    (skip_i),
  .skip_idx_i(skip_idx_i),
  .flag_o    (flag_o),
  .skip_hit_o(skip_hit_o),
  .irq_o     (irq_o),
  .irq_idx_o (irq_idx_o),
  .cfg_o     (cfg_o),
  .ien_q     (ien_q),
  .set_vec   (set_vec)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic [1:0]     pin_i;
  logic [1:0]     cfg_we_i;
  logic [3:0]     cfg_wdata_i;
  logic [7:0]     cfg_o;
  logic           ien_we_i;
  logic [1:0]     ien_wdata_i;
  logic           gie_i;
  logic           ack_i;
  logic [0:0]     ack_idx_i;
  logic           skip_i;
  logic [0:0]     skip_idx_i;
  logic [1:0]     flag_o;
  logic           skip_hit_o;
  logic           irq_o;
  logic [0:0]     irq_idx_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NCH(NCH)) u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_o(cfg_o), .ien_we_i(ien_we_i),
    .ien_wdata_i(ien_wdata_i), .gie_i(gie_i), .ack_i(ack_i),
    .ack_idx_i(ack_idx_i), .skip_i(skip_i), .skip_idx_i(skip_idx_i),
    .flag_o(flag_o), .skip_hit_o(skip_hit_o), .irq_o(irq_o),
    .irq_idx_o(irq_idx_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int ch, input logic [3:0] v);
    cfg_we_i[ch] = 1'b1; cfg_wdata_i = v;
    step(1);
    cfg_we_i = '0;
  endtask

  task automatic wr_ien(input logic [1:0] v);
    ien_we_i = 1'b1; ien_wdata_i = v;
    step(1);
    ien_we_i = 1'b0;
  endtask

  task automatic do_skip(input int ch);
    skip_i = 1'b1; skip_idx_i = 1'(ch);
    step(1);
    skip_i = 1'b0;
  endtask

  task automatic do_ack(input int ch);
    ack_i = 1'b1; ack_idx_i = 1'(ch);
    step(1);
    ack_i = 1'b0;
  endtask

  task automatic drive_pin(input int ch, input logic v);
    pin_i[ch] = v;
    step(10);
  endtask

  task automatic t_reset;
    chk("R10 flags after reset", flag_o, 0);
    chk("R10 irq after reset", irq_o, 0);
    chk("R10 irq_idx after reset", irq_idx_o, 0);
    chk("R10 skip_hit after reset", skip_hit_o, 0);
    chk("R10 cfg after reset", cfg_o, 0);
  endtask

  task automatic t_cfg;
    wr_cfg(0, 4'b0011);
    wr_cfg(1, 4'b0101);
    chk("R1 cfg0 readback", cfg_o[3:0], 4'b0011);
    chk("R1 cfg1 readback", cfg_o[7:4], 4'b0101);
    step(4);
    chk("R4 disabled channels stay clear", flag_o, 0);
  endtask

  task automatic t_filter;
    wr_cfg(0, 4'b1010);
    step(8);
    pin_i[0] = 1'b1; step(3); pin_i[0] = 1'b0;
    step(12);
    chk("R2 three-clock pulse ignored", flag_o[0], 0);
    pin_i[0] = 1'b1;
    step(5);
    chk("R2 flag still low at edge k+4", flag_o[0], 0);
    step(1);
    chk("R2 flag set at edge k+5", flag_o[0], 1);
    do_skip(0);
    drive_pin(0, 1'b0);
    chk("R3 falling ignored in rising mode", flag_o[0], 0);
  endtask

  task automatic t_edges;
    wr_cfg(0, 4'b1000);
    drive_pin(0, 1'b1);
    chk("R3 rising ignored in falling mode", flag_o[0], 0);
    drive_pin(0, 1'b0);
    chk("R3 falling accepted in falling mode", flag_o[0], 1);
    do_skip(0);
    wr_cfg(0, 4'b1100);
    drive_pin(0, 1'b1);
    chk("R3 rising accepted in both mode", flag_o[0], 1);
    do_skip(0);
    drive_pin(0, 1'b0);
    chk("R3 falling accepted in both mode", flag_o[0], 1);
    do_skip(0);
    wr_cfg(0, 4'b1110);
    drive_pin(0, 1'b1);
    chk("R3 code 11 also both edges", flag_o[0], 1);
    do_skip(0);
    drive_pin(0, 1'b0);
    do_skip(0);
  endtask

  task automatic t_enable;
    wr_cfg(1, 4'b0100);
    drive_pin(1, 1'b1);
    drive_pin(1, 1'b0);
    drive_pin(1, 1'b1);
    chk("R4 disabled pin sets nothing", flag_o[1], 0);
    wr_cfg(1, 4'b1100);
    step(10);
    chk("R4 enabling with pin high adds no edge", flag_o[1], 0);
    drive_pin(1, 1'b0);
    chk("R4 enabled pin sets flag", flag_o[1], 1);
    do_skip(1);
  endtask

  task automatic t_ack;
    pin_i = 2'b11; step(10);
    chk("R5 both flags set", flag_o, 2'b11);
    do_ack(1);
    chk("R5 ack 1 clears only channel 1", flag_o, 2'b01);
    do_ack(0);
    chk("R5 ack 0 clears channel 0", flag_o, 2'b00);
  endtask

  task automatic t_skip;
    pin_i[0] = 1'b0; step(10);
    do_skip(1);
    chk("R6 skip on clear flag reports 0", skip_hit_o, 0);
    chk("R6 skip on other channel keeps flag", flag_o[0], 1);
    do_skip(0);
    chk("R6 skip on set flag reports 1", skip_hit_o, 1);
    chk("R6 skip clears flag", flag_o[0], 0);
    step(1);
    chk("R6 skip_hit idle low", skip_hit_o, 0);
  endtask

  task automatic t_irq;
    gie_i = 1'b1;
    pin_i[0] = 1'b1; step(10);
    chk("R7 no irq without channel enable", irq_o, 0);
    gie_i = 1'b0;
    wr_ien(2'b01);
    step(2);
    chk("R7 no irq without global enable", irq_o, 0);
    gie_i = 1'b1;
    step(1);
    chk("R7 irq one cycle after enables", irq_o, 1);
    chk("R7 irq index channel 0", irq_idx_o, 0);
    do_ack(0);
    step(1);
    chk("R7 irq drops after acceptance", irq_o, 0);
  endtask

  task automatic t_prio;
    gie_i = 1'b0;
    wr_ien(2'b11);
    pin_i = 2'b00; step(10);
    chk("R8 both flags pending", flag_o, 2'b11);
    gie_i = 1'b1;
    step(1);
    chk("R8 irq raised", irq_o, 1);
    chk("R8 channel 0 first", irq_idx_o, 0);
    do_ack(0);
    step(1);
    chk("R8 channel 1 next", irq_idx_o, 1);
    chk("R8 irq still raised", irq_o, 1);
    do_ack(1);
    step(1);
    chk("R8 irq idle", irq_o, 0);
    gie_i = 1'b0;
    wr_ien(2'b00);
  endtask

  task automatic t_setwins;
    pin_i[0] = 1'b1; step(10);
    chk("R9 flag set before collision", flag_o[0], 1);
    pin_i[0] = 1'b0;
    step(5);
    ack_i = 1'b1; ack_idx_i = 1'b0;
    step(1);
    ack_i = 1'b0;
    chk("R9 set beats acknowledge", flag_o[0], 1);
    step(4);
    pin_i[0] = 1'b1;
    step(5);
    skip_i = 1'b1; skip_idx_i = 1'b0;
    step(1);
    skip_i = 1'b0;
    chk("R9 set beats skip-test", flag_o[0], 1);
    chk("R9 skip still reports set", skip_hit_o, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; pin_i = '0; cfg_we_i = '0; cfg_wdata_i = '0;
    ien_we_i = 1'b0; ien_wdata_i = '0; gie_i = 1'b0;
    ack_i = 1'b0; ack_idx_i = '0; skip_i = 1'b0; skip_idx_i = '0;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset;
    t_cfg;
    t_filter;
    t_edges;
    t_enable;
    t_ack;
    t_skip;
    t_irq;
    t_prio;
    t_setwins;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule